// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block snoops the processor's bus cycles on three buses (an instruction-fetch address bus, a memory-access bus and an internal bus) and raises a break request when a programmed condition is met. Two channels each hold their own condition. A channel compares the address of its chosen bus against a value under a per-bit mask. It can also compare data, the cycle kind, the direction and the access size. Each of those fields has its own enable, and a field that is switched off always counts as matching.

Configuration arrives over a simple register write port. Three outputs are registered: a per-channel hit flag, a one-clock trigger pulse per matching cycle, and a combined break request. A break on an instruction fetch can be requested at once (before execution) or deferred until the next instruction-complete strobe (after execution). A sticky per-channel status flag records each hit until software clears it by writing 1.

Each channel runs a small state machine. Its states are `CH_OFF` (no field enabled), `CH_WATCH` (armed) and `CH_PEND` (a deferred fetch break is waiting). Its transitions are: arm, when any enable is set, from `CH_OFF` to `CH_WATCH`, or straight to `CH_PEND` when the arming cycle already holds a deferred match; defer, on a deferred match, from `CH_WATCH` to `CH_PEND`; release, on the instruction-complete strobe, from `CH_PEND` back to `CH_WATCH` (or to `CH_OFF` if disabled); and disarm, when all enables clear, from any state to `CH_OFF`.

Top module: `bus_break_unit`

## Requirements
- R1: The two channels are evaluated independently. `chan_hit[n]` is high for one cycle, one clock edge after the bus cycle that satisfies channel n's condition.
- R2: With the address enable (control bit 0) set, an address bit whose mask bit is 1 is ignored. Every other bit must equal the programmed address value.
- R3: Control bits [2:1] pick the address source: 0 is the fetch bus, 1 the memory bus, 2 the internal bus. Code 3 never matches.
- R4: With the data enable (bit 3) set, the data compare is masked per bit in the same way as the address. It reads the memory data bus when bit 4 is 0 and the internal data bus when bit 4 is 1, in the same cycle as the address.
- R5: With the cycle enable (bit 5) set, bit 6 = 1 matches only on the fetch source and bit 6 = 0 matches only on the memory or internal source.
- R6: A match needs the valid strobe of the selected bus. With bit 7 set, bit 8 must equal the bus write flag (1 = write). With bit 9 set, bits [11:10] must equal the size code (0 byte, 1 word, 2 longword). The fetch bus is always a longword read.
- R7: A channel whose five enables (bits 0, 3, 5, 7, 9) are all 0 never matches.
- R8: When bit 12 is set and the source is the fetch bus, a match does not request at once. It is held, and `break_req` goes high one edge after `insn_done` is sampled high.
- R9: Any other match drives `break_req` and `trig_pulse` high one edge after the matching cycle.
- R10: A match sets the sticky `status_flags[n]`. Writing 1 to bit n at register 7 clears it.
- R11: After reset all outputs are 0. Configuration registers are at `cfg_addr` = {channel, reg}, with reg 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | {channel, register} select |
| cfg_wdata | input | 32 | Configuration write data |
| fetch_valid | input | 1 | Fetch bus cycle valid |
| fetch_addr | input | 32 | Fetch bus address |
| mem_valid | input | 1 | Memory bus cycle valid |
| mem_write | input | 1 | Memory bus write flag |
| mem_size | input | 2 | Memory bus size code |
| mem_addr | input | 32 | Memory bus address |
| mem_data | input | 32 | Memory bus data |
| int_valid | input | 1 | Internal bus cycle valid |
| int_write | input | 1 | Internal bus write flag |
| int_size | input | 2 | Internal bus size code |
| int_addr | input | 32 | Internal bus address |
| int_data | input | 32 | Internal bus data |
| insn_done | input | 1 | Instruction-complete strobe |
| chan_hit | output | 2 | Per-channel match flag |
| status_flags | output | 2 | Sticky per-channel hit status |
| trig_pulse | output | 1 | One-clock trigger per matching cycle |
| break_req | output | 1 | Combined break request |

## Verification
The hardest condition to reach is a channel where several enabled fields must agree at once. Random 32-bit values almost never satisfy a masked address and a masked data compare together. The stimulus therefore draws the bus cycle first and builds each channel's programmed values from it, flipping only masked bits most of the time. It also copies the cycle kind, direction and size from the selected bus with high probability. This way both full matches and single-field misses occur often. Directed trials add the all-disabled channel, the unused source code and a forced deferred fetch break released by `insn_done`.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;

    localparam logic [1:0] SRC_FETCH = 2'd0;
    localparam logic [1:0] SRC_MEM   = 2'd1;
    localparam logic [1:0] SRC_INT   = 2'd2;
    localparam logic [1:0] SZ_LONG   = 2'd2;

    localparam logic [2:0] REG_AVAL  = 3'd0;
    localparam logic [2:0] REG_AMASK = 3'd1;
    localparam logic [2:0] REG_DVAL  = 3'd2;
    localparam logic [2:0] REG_DMASK = 3'd3;
    localparam logic [2:0] REG_CTL   = 3'd4;
    localparam logic [2:0] REG_CLR   = 3'd7;

    typedef struct packed {
        logic       after_exec;  // 12
        logic [1:0] size;        // 11:10
        logic       size_en;     // 9
        logic       dir_wr;      // 8
        logic       dir_en;      // 7
        logic       cyc_fetch;   // 6
        logic       cyc_en;      // 5
        logic       data_src;    // 4
        logic       data_en;     // 3
        logic [1:0] addr_src;    // 2:1
        logic       addr_en;     // 0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic [ADDR_W-1:0] addr_val;
        logic [ADDR_W-1:0] addr_mask;
        logic [DATA_W-1:0] data_val;
        logic [DATA_W-1:0] data_mask;
        ctl_t              ctl;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_WATCH = 2'd1,
        CH_PEND  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/bbu_cfg_regs.sv
module bbu_cfg_regs
    import bbu_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CFG_AW = $clog2(NUM_CH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CFG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [NUM_CH-1:0] hit_set_i,
    output chan_cfg_t         cfg_o [NUM_CH],
    output logic [NUM_CH-1:0] status_o
);

    localparam int SEL_W = CFG_AW - 3;

    logic [2:0] reg_sel;
    assign reg_sel = addr_i[2:0];

    logic clr_write;
    assign clr_write = we_i && (reg_sel == REG_CLR);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic      ch_sel;
        chan_cfg_t cfg_q;
        logic      stat_q;

        assign ch_sel = we_i && (addr_i[CFG_AW-1:3] == SEL_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (ch_sel) begin
                unique case (reg_sel)
                    REG_AVAL:  cfg_q.addr_val  <= wdata_i[ADDR_W-1:0];
                    REG_AMASK: cfg_q.addr_mask <= wdata_i[ADDR_W-1:0];
                    REG_DVAL:  cfg_q.data_val  <= wdata_i[DATA_W-1:0];
                    REG_DMASK: cfg_q.data_mask <= wdata_i[DATA_W-1:0];
                    REG_CTL:   cfg_q.ctl       <= ctl_t'(wdata_i[CTL_W-1:0]);
                    default:   ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q <= 1'b0;
            end else begin
                stat_q <= hit_set_i[c] | (stat_q & ~(clr_write & wdata_i[c]));
            end
        end

        assign cfg_o[c]    = cfg_q;
        assign status_o[c] = stat_q;

        assert_clear_drops_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_write && wdata_i[c] && !hit_set_i[c]) |=> !status_o[c]);
    end

endmodule

// File: rtl/bbu_matcher.sv
module bbu_matcher
    import bbu_pkg::*;
(
    input  chan_cfg_t         cfg_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              mem_valid_i,
    input  logic              mem_write_i,
    input  logic [1:0]        mem_size_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              int_valid_i,
    input  logic              int_write_i,
    input  logic [1:0]        int_size_i,
    input  logic [ADDR_W-1:0] int_addr_i,
    input  logic [DATA_W-1:0] int_data_i,
    output logic              on_o,
    output logic              defer_o,
    output logic              match_o
);

    ctl_t              ctl;
    logic              sel_valid;
    logic              sel_write;
    logic [1:0]        sel_size;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    logic              is_fetch;
    logic              addr_ok, data_ok, cyc_ok, dir_ok, size_ok;

    assign ctl = cfg_i.ctl;

    always_comb begin
        sel_valid = 1'b0;
        sel_write = 1'b0;
        sel_size  = SZ_LONG;
        sel_addr  = '0;
        unique case (ctl.addr_src)
            SRC_FETCH: begin
                sel_valid = fetch_valid_i;
                sel_addr  = fetch_addr_i;
            end
            SRC_MEM: begin
                sel_valid = mem_valid_i;
                sel_write = mem_write_i;
                sel_size  = mem_size_i;
                sel_addr  = mem_addr_i;
            end
            SRC_INT: begin
                sel_valid = int_valid_i;
                sel_write = int_write_i;
                sel_size  = int_size_i;
                sel_addr  = int_addr_i;
            end
            default: sel_valid = 1'b0;
        endcase
    end

    assign sel_data = ctl.data_src ? int_data_i : mem_data_i;
    assign is_fetch = (ctl.addr_src == SRC_FETCH);

    assign addr_ok = !ctl.addr_en || (((sel_addr ^ cfg_i.addr_val) & ~cfg_i.addr_mask) == '0);
    assign data_ok = !ctl.data_en || (((sel_data ^ cfg_i.data_val) & ~cfg_i.data_mask) == '0);
    assign cyc_ok  = !ctl.cyc_en  || (ctl.cyc_fetch == is_fetch);
    assign dir_ok  = !ctl.dir_en  || (ctl.dir_wr == sel_write);
    assign size_ok = !ctl.size_en || (ctl.size == sel_size);

    assign on_o    = ctl.addr_en | ctl.data_en | ctl.cyc_en | ctl.dir_en | ctl.size_en;
    assign defer_o = ctl.after_exec && is_fetch;
    assign match_o = on_o && sel_valid && addr_ok && data_ok && cyc_ok && dir_ok && size_ok;

endmodule

// File: rtl/bbu_chan_fsm.sv
module bbu_chan_fsm
    import bbu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic match_i,
    input  logic defer_i,
    input  logic insn_done_i,
    output logic req_now_o,
    output logic pending_o
);

    ch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (on_i) state_d = (match_i && defer_i) ? CH_PEND : CH_WATCH;
            end
            CH_WATCH: begin
                if (!on_i)                   state_d = CH_OFF;
                else if (match_i && defer_i) state_d = CH_PEND;
            end
            CH_PEND: begin
                if (insn_done_i) state_d = on_i ? CH_WATCH : CH_OFF;
                else if (!on_i)  state_d = CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        pending_o = (state_q == CH_PEND);
        req_now_o = (match_i && !defer_i) || (pending_o && insn_done_i);
    end

    assert_pend_release_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PEND && insn_done_i) |=> (state_q != CH_PEND));

    assert_pend_entry_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CH_PEND) |-> $past(match_i && defer_i));

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import bbu_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CFG_AW = $clog2(NUM_CH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic [1:0]        mem_size,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              int_valid,
    input  logic              int_write,
    input  logic [1:0]        int_size,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [DATA_W-1:0] int_data,
    input  logic              insn_done,
    output logic [NUM_CH-1:0] chan_hit,
    output logic [NUM_CH-1:0] status_flags,
    output logic              trig_pulse,
    output logic              break_req
);

    chan_cfg_t         cfg [NUM_CH];
    logic [NUM_CH-1:0] ch_on, ch_defer, ch_match, ch_req, ch_pend;

    bbu_cfg_regs #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we),
        .addr_i    (cfg_addr),
        .wdata_i   (cfg_wdata),
        .hit_set_i (ch_match),
        .cfg_o     (cfg),
        .status_o  (status_flags)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        bbu_matcher u_match (
            .cfg_i         (cfg[c]),
            .fetch_valid_i (fetch_valid),
            .fetch_addr_i  (fetch_addr),
            .mem_valid_i   (mem_valid),
            .mem_write_i   (mem_write),
            .mem_size_i    (mem_size),
            .mem_addr_i    (mem_addr),
            .mem_data_i    (mem_data),
            .int_valid_i   (int_valid),
            .int_write_i   (int_write),
            .int_size_i    (int_size),
            .int_addr_i    (int_addr),
            .int_data_i    (int_data),
            .on_o          (ch_on[c]),
            .defer_o       (ch_defer[c]),
            .match_o       (ch_match[c])
        );

        bbu_chan_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .on_i        (ch_on[c]),
            .match_i     (ch_match[c]),
            .defer_i     (ch_defer[c]),
            .insn_done_i (insn_done),
            .req_now_o   (ch_req[c]),
            .pending_o   (ch_pend[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_hit   <= '0;
            trig_pulse <= 1'b0;
            break_req  <= 1'b0;
        end else begin
            chan_hit   <= ch_match;
            trig_pulse <= |ch_match;
            break_req  <= |ch_req;
        end
    end

    assert_trig_status_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (|status_flags));

    assert_hit_needs_valid_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_hit) |-> $past(fetch_valid | mem_valid | int_valid));

    assert_req_has_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        break_req |-> ($past(|ch_match) || $past(insn_done)));

endmodule

// File: tb/test_bus_break_unit.sv
`timescale 1ns/1ps
module test_bus_break_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        mem_valid = 1'b0, mem_write = 1'b0;
    logic [1:0]  mem_size = '0;
    logic [31:0] mem_addr = '0, mem_data = '0;
    logic        int_valid = 1'b0, int_write = 1'b0;
    logic [1:0]  int_size = '0;
    logic [31:0] int_addr = '0, int_data = '0;
    logic        insn_done = 1'b0;
    logic [1:0]  chan_hit, status_flags;
    logic        trig_pulse, break_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] cav [2], cam [2], cdv [2], cdm [2];
    logic [12:0] cct [2];

    always #10 clk = ~clk;

    bus_break_unit i_bus_break_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .int_valid(int_valid), .int_write(int_write), .int_size(int_size),
        .int_addr(int_addr), .int_data(int_data), .insn_done(insn_done),
        .chan_hit(chan_hit), .status_flags(status_flags),
        .trig_pulse(trig_pulse), .break_req(break_req)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] src_addr(logic [1:0] s);
        case (s)
            2'd0: return fetch_addr;
            2'd1: return mem_addr;
            2'd2: return int_addr;
            default: return 32'h0;
        endcase
    endfunction

    // Bench model of one channel's condition, from the requirements
    function automatic logic model_hit(int ch);
        logic [12:0] t = cct[ch];
        logic [1:0]  s = t[2:1];
        logic v, w, on;
        logic [1:0] sz;
        logic [31:0] a, d;
        on = t[0] | t[3] | t[5] | t[7] | t[9];
        case (s)
            2'd0: begin v = fetch_valid; w = 1'b0;      sz = 2'd2;     end
            2'd1: begin v = mem_valid;   w = mem_write; sz = mem_size; end
            2'd2: begin v = int_valid;   w = int_write; sz = int_size; end
            default: begin v = 1'b0; w = 1'b0; sz = 2'd0; end
        endcase
        a = src_addr(s);
        d = t[4] ? int_data : mem_data;
        if (!on || !v) return 1'b0;
        if (t[0] && (((a ^ cav[ch]) & ~cam[ch]) != 0)) return 1'b0;
        if (t[3] && (((d ^ cdv[ch]) & ~cdm[ch]) != 0)) return 1'b0;
        if (t[5] && (t[6] != (s == 2'd0))) return 1'b0;
        if (t[7] && (t[8] != w)) return 1'b0;
        if (t[9] && (t[11:10] != sz)) return 1'b0;
        return 1'b1;
    endfunction

    // mode 0 random, 1 all enables off, 2 unused source, 3 deferred fetch break
    task automatic trial(int mode);
        logic [1:0] m, dfr, pend;
        logic [31:0] fa, ma, md, ia, idat;
        logic fv, mv, mw, iv, iw;
        logic [1:0] ms, isz;
        fa = $urandom; ma = $urandom; md = $urandom; ia = $urandom; idat = $urandom;
        fv = ($urandom % 4) != 0; mv = ($urandom % 4) != 0; iv = ($urandom % 4) != 0;
        mw = $urandom % 2; iw = $urandom % 2;
        ms = 2'($urandom % 3); isz = 2'($urandom % 3);
        if (mode != 0) begin fv = 1'b1; mv = 1'b1; iv = 1'b1; end
        for (int ch = 0; ch < 2; ch++) begin
            logic [1:0] s;
            logic [31:0] sa, sd;
            logic sw;
            logic [1:0] ssz;
            logic [12:0] t;
            s = 2'($urandom % 4);
            if (mode == 2) s = 2'd3;
            if (mode == 3) s = 2'd0;
            sa = (s == 0) ? fa : (s == 1) ? ma : (s == 2) ? ia : 32'h0;
            sw = (s == 1) ? mw : (s == 2) ? iw : 1'b0;
            ssz = (s == 1) ? ms : (s == 2) ? isz : 2'd2;
            cam[ch] = $urandom & $urandom & $urandom;
            cav[ch] = (($urandom % 4) != 0) ? (sa ^ ($urandom & cam[ch])) : $urandom;
            t = 13'($urandom);
            t[2:1] = s;
            sd = t[4] ? idat : md;
            cdm[ch] = $urandom & $urandom;
            cdv[ch] = (($urandom % 4) != 0) ? (sd ^ ($urandom & cdm[ch])) : $urandom;
            if (($urandom % 4) != 0) t[6] = (s == 0);
            if (($urandom % 4) != 0) t[8] = sw;
            if (($urandom % 4) != 0) t[11:10] = ssz;
            if (mode == 1) begin t[0] = 0; t[3] = 0; t[5] = 0; t[7] = 0; t[9] = 0; end
            if (mode == 2) t[0] = 1'b1;
            if (mode == 3) begin
                t = 13'h1001;
                cam[ch] = 32'h0;
                cav[ch] = fa;
            end
            cct[ch] = t;
            wr({ch[0], 3'd0}, cav[ch]);
            wr({ch[0], 3'd1}, cam[ch]);
            wr({ch[0], 3'd2}, cdv[ch]);
            wr({ch[0], 3'd3}, cdm[ch]);
            wr({ch[0], 3'd4}, 32'(t));
        end
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa;
        mem_valid = mv; mem_write = mw; mem_size = ms; mem_addr = ma; mem_data = md;
        int_valid = iv; int_write = iw; int_size = isz; int_addr = ia; int_data = idat;
        for (int ch = 0; ch < 2; ch++) begin
            m[ch]   = model_hit(ch);
            dfr[ch] = cct[ch][12] && (cct[ch][2:1] == 2'd0);
        end
        pend = m & dfr;
        @(posedge clk);
        #1;
        // hit covers R1 R2 R3 R4 R5 R6 R7
        chk("R1 R2 R3 R4 R5 R6 R7 chan_hit", 32'(chan_hit), 32'(m));
        chk("R9 trig_pulse", 32'(trig_pulse), 32'(|m));
        chk("R9 R8 break_req at match", 32'(break_req), 32'(|(m & ~dfr)));
        chk("R10 status set", 32'(status_flags), 32'(m));
        @(negedge clk);
        fetch_valid = 1'b0; mem_valid = 1'b0; int_valid = 1'b0;
        insn_done = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 break_req after insn_done", 32'(break_req), 32'(|pend));
        chk("R1 chan_hit idle", 32'(chan_hit), 32'h0);
        @(negedge clk);
        insn_done = 1'b0;
        wr(4'd7, 32'h3);
        chk("R10 status cleared", 32'(status_flags), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset chan_hit", 32'(chan_hit), 32'h0);
        chk("R11 reset status", 32'(status_flags), 32'h0);
        chk("R11 reset trig", 32'(trig_pulse), 32'h0);
        chk("R11 reset break_req", 32'(break_req), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        trial(1);   // R7 directed
        trial(2);   // R3 directed
        trial(3);   // R8 directed
        for (int i = 0; i < 400; i++) trial(0);
        trial(3);
        done = 1;
        summary();
    end

endmodule